// File: doc/BRIEF.md
# E1 Timeslot Zero Word Generator

This block produces the eight bits that fill timeslot 0 of a 2.048 Mbit/s PCM frame of 32 timeslots, with 256 bit periods per frame. Frames alternate between a frame-alignment word and a non-alignment word. The word is sent serially, first bit first, during the first eight bit periods of each frame. A flag output reports which of the two word types the current frame carries, so that a downstream CRC stage can follow the alternation.

A single-cycle frame-start pulse sets the frame position. The clock edge that samples the pulse opens a new frame. While pulses are absent, an internal bit counter runs freely and opens a new frame every 256 clocks. Six parallel user bits fill the tail of the non-alignment word. A separate serial spare-bit input supplies the first bit of every word. Both are captured at the edge that opens the frame, so later changes cannot corrupt a word that is already being sent.

Top module: `e1_ts0_gen`

## Requirements
- R1: After reset and before the first frame-start pulse, `ts0_mark`, `ts0_data` and `sync_frame` are all 0, whatever the data inputs do.
- R2: The clock edge that samples `frame_start` high opens a frame. `ts0_mark` is 1 for the 8 clocks that follow that edge and 0 for the other 248 clocks of the frame.
- R3: `sync_frame` inverts at every frame opening, and the first frame after reset carries the alignment word (`sync_frame` = 1).
- R4: In an alignment frame, bits 2 to 8 on `ts0_data` are 0,0,1,1,0,1,1, in the 2nd to 8th clocks of the mark.
- R5: In a non-alignment frame, bit 2 is 1, and bits 3 to 8 are `user_bits[5]` down to `user_bits[0]`.
- R6: Bit 1 of every word, sent in the first clock of the mark, equals `spare_bit` as sampled at the edge that opened the frame.
- R7: `user_bits` and `spare_bit` are captured only at the edge that opens a frame. Changes at any other time do not alter the word being sent.
- R8: `ts0_data` is 0 in every clock where `ts0_mark` is 0.
- R9: Once a frame has begun, if no further pulse arrives, a new frame opens 256 clocks after the previous one. This frame toggles `sync_frame` and captures the inputs as in R3 to R7.
- R10: A `frame_start` pulse at any point in a frame, including during the mark, restarts the frame at bit 1 on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 2.048 MHz bit clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-clock pulse that opens a frame |
| user_bits | input | 6 | Bits 3 to 8 of the non-alignment word, bit 5 sent first |
| spare_bit | input | 1 | Serial source of bit 1 of each word |
| ts0_data | output | 1 | Serial timeslot-0 data, 0 outside the slot |
| ts0_mark | output | 1 | High during the 8 clocks of timeslot 0 |
| sync_frame | output | 1 | 1 when the current frame carries the alignment word |

## Verification
All three outputs come from registers with no logic stage between the opening edge and the first bit. The clock after the edge that samples `frame_start` therefore already shows bit 1, the raised mark and the new `sync_frame` value. Bit k of the word appears k−1 clocks later, and `ts0_mark` falls 8 clocks after the opening edge. The bench drives the inputs on falling edges. After each rising edge it updates a model built from the requirements, and it compares the outputs on the next falling edge. Every comparison therefore lands exactly one clock after the stimulus it depends on. The flywheel frame is checked 256 clocks after the last opening.

// File: rtl/e1ts0_pkg.sv
package e1ts0_pkg;

    localparam int SLOT_BITS  = 8;
    localparam int USER_W     = 6;
    localparam int IDX_W      = $clog2(SLOT_BITS);

    // fixed tail of the alignment word, bit 2 first
    localparam logic [SLOT_BITS-2:0] ALIGN_TAIL = 7'b0011011;

    typedef struct packed {
        logic                   spare;
        logic [SLOT_BITS-2:0]   tail;
    } ts0_word_t;

    function automatic ts0_word_t build_word(
        input logic              is_align,
        input logic              spare,
        input logic [USER_W-1:0] user
    );
        ts0_word_t w;
        w.spare = spare;
        if (is_align) w.tail = ALIGN_TAIL;
        else          w.tail = {1'b1, user};
        return w;
    endfunction

endpackage

// File: rtl/e1ts0_timer.sv
module e1ts0_timer #(
    parameter int FRAME_BITS = 256,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    output logic             frame_open,
    output logic             locked,
    output logic [CNT_W-1:0] bit_pos
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

    always_comb begin
        frame_open = frame_start || (locked && (bit_pos == LAST_POS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked  <= 1'b0;
            bit_pos <= '0;
        end else if (frame_open) begin
            locked  <= 1'b1;
            bit_pos <= '0;
        end else if (locked) begin
            bit_pos <= bit_pos + 1'b1;
        end
    end
endmodule

// File: rtl/e1ts0_word_reg.sv
module e1ts0_word_reg
    import e1ts0_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_open,
    input  logic              spare_bit,
    input  logic [USER_W-1:0] user_bits,
    output logic              is_align,
    output ts0_word_t         word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            is_align <= 1'b0;
            word     <= '0;
        end else if (frame_open) begin
            is_align <= !is_align;
            word     <= build_word(!is_align, spare_bit, user_bits);
        end
    end
endmodule

// File: rtl/e1ts0_serializer.sv
module e1ts0_serializer
    import e1ts0_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             locked,
    input  logic [CNT_W-1:0] bit_pos,
    input  ts0_word_t        word,
    output logic             ts0_mark,
    output logic             ts0_data
);
    logic [SLOT_BITS-1:0] flat;
    logic [IDX_W-1:0]     idx;

    always_comb begin
        flat     = word;
        idx      = bit_pos[IDX_W-1:0];
        ts0_mark = locked && (bit_pos[CNT_W-1:IDX_W] == '0);
        ts0_data = ts0_mark && flat[(SLOT_BITS-1) - int'(idx)];
    end
endmodule

// File: rtl/e1_ts0_gen.sv
module e1_ts0_gen
    import e1ts0_pkg::*;
#(
    parameter int SLOT_COUNT = 32,
    localparam int FRAME_BITS = SLOT_COUNT * SLOT_BITS,
    localparam int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [USER_W-1:0] user_bits,
    input  logic              spare_bit,
    output logic              ts0_data,
    output logic              ts0_mark,
    output logic              sync_frame
);
    logic             frame_open;
    logic             locked;
    logic [CNT_W-1:0] bit_pos;
    ts0_word_t        word;

    e1ts0_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .frame_open (frame_open),
        .locked     (locked),
        .bit_pos    (bit_pos)
    );

    e1ts0_word_reg u_word (
        .clk       (clk),
        .rst       (rst),
        .frame_open(frame_open),
        .spare_bit (spare_bit),
        .user_bits (user_bits),
        .is_align  (sync_frame),
        .word      (word)
    );

    e1ts0_serializer #(.CNT_W(CNT_W)) u_ser (
        .locked  (locked),
        .bit_pos (bit_pos),
        .word    (word),
        .ts0_mark(ts0_mark),
        .ts0_data(ts0_data)
    );
endmodule

// File: rtl/e1ts0_checker.sv
module e1ts0_checker (
    input logic clk,
    input logic rst,
    input logic frame_start,
    input logic spare_bit,
    input logic ts0_data,
    input logic ts0_mark,
    input logic sync_frame
);
    localparam logic [7:0] ALIGN_WORD = 8'b0001_1011;

    logic       seen_start;
    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_start <= 1'b0;
            run_q      <= '0;
        end else begin
            if (frame_start) seen_start <= 1'b1;
            if (frame_start)   run_q <= '0;
            else if (ts0_mark) run_q <= run_q + 1'b1;
            else               run_q <= '0;
        end
    end

    assert_idle_before_start_R1: assert property (@(posedge clk) disable iff (rst)
        !seen_start |-> (!ts0_mark && !ts0_data && !sync_frame));

    assert_mark_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> ts0_mark);

    assert_mark_max_len_R2: assert property (@(posedge clk) disable iff (rst)
        ts0_mark |-> (run_q < 4'd8));

    assert_mark_ends_R2: assert property (@(posedge clk) disable iff (rst)
        (ts0_mark && run_q == 4'd7 && !frame_start) |=> !ts0_mark);

    assert_phase_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (sync_frame != $past(sync_frame)));

    assert_align_bits_R4: assert property (@(posedge clk) disable iff (rst)
        (ts0_mark && sync_frame && run_q != 4'd0) |-> (ts0_data == ALIGN_WORD[3'd7 - run_q[2:0]]));

    assert_nonalign_bit2_R5: assert property (@(posedge clk) disable iff (rst)
        (ts0_mark && !sync_frame && run_q == 4'd1) |-> ts0_data);

    assert_spare_bit_R6: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (ts0_data == $past(spare_bit)));

    assert_quiet_outside_R8: assert property (@(posedge clk) disable iff (rst)
        !ts0_mark |-> !ts0_data);
endmodule

bind e1_ts0_gen e1ts0_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .spare_bit  (spare_bit),
    .ts0_data   (ts0_data),
    .ts0_mark   (ts0_mark),
    .sync_frame (sync_frame)
);

// File: tb/tb_e1_ts0_gen.sv
module tb_e1_ts0_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic [5:0] user_bits = '0;
    logic       spare_bit = 1'b0;
    logic       ts0_data, ts0_mark, sync_frame;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state, from the requirements
    bit         m_locked = 1'b0;
    int         m_pos    = 0;
    bit         m_align  = 1'b0;
    logic [7:0] m_word   = '0;

    always #2.5 clk = ~clk;

    e1_ts0_gen dut (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .user_bits(user_bits), .spare_bit(spare_bit),
        .ts0_data(ts0_data), .ts0_mark(ts0_mark), .sync_frame(sync_frame)
    );

    function automatic logic [7:0] exp_word(bit align, logic sp, logic [5:0] ub);
        if (align) return {sp, 7'b0011011};
        return {sp, 1'b1, ub};
    endfunction

    task automatic chk(bit ok, string tag, string ctx, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s (%s) actual=%0d expected=%0d t=%0t", tag, ctx, act, exp, $time);
        end
    endtask

    // drive inputs now (falling edge), model the rising edge, check at next falling edge
    task automatic tick(bit fs, string ctx);
        logic [5:0] ub;
        logic       sp;
        bit         open;
        bit         e_mark;
        logic       e_data;
        string      tag;
        ub = 6'($urandom);
        sp = 1'($urandom);
        frame_start = fs;
        user_bits   = ub;
        spare_bit   = sp;
        @(posedge clk);
        open = fs || (m_locked && m_pos == 255);
        if (open) begin
            m_locked = 1'b1;
            m_pos    = 0;
            m_align  = !m_align;
            m_word   = exp_word(m_align, sp, ub);
        end else if (m_locked) begin
            m_pos = m_pos + 1;
        end
        @(negedge clk);
        e_mark = m_locked && m_pos < 8;
        e_data = e_mark ? m_word[7 - m_pos] : 1'b0;
        if (!m_locked)       tag = "R1";
        else if (!e_mark)    tag = "R8";
        else if (m_pos == 0) tag = "R6";
        else if (m_align)    tag = "R4";
        else                 tag = "R5";
        chk(ts0_data == e_data, tag, ctx, int'(ts0_data), int'(e_data));
        chk(ts0_mark == e_mark, m_locked ? "R2" : "R1", ctx, int'(ts0_mark), int'(e_mark));
        chk(sync_frame == m_align, m_locked ? "R3" : "R1", ctx, int'(sync_frame), int'(m_align));
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: inputs toggle, no pulse yet
        for (int i = 0; i < 20; i++) tick(1'b0, "idle before first pulse R1");
        // regular frames; inputs randomised every clock covers R7
        for (int f = 0; f < 12; f++) begin
            tick(1'b1, "pulse opens frame R2");
            for (int i = 0; i < 255; i++) tick(1'b0, "regular frame R7");
        end
        // flywheel frames: no pulses
        for (int i = 0; i < 3 * 256; i++) tick(1'b0, "flywheel R9");
        // early pulses at random points, including inside the mark
        for (int f = 0; f < 10; f++) begin
            int n;
            n = (f % 3 == 0) ? 1 + int'($urandom % 7) : 8 + int'($urandom % 240);
            tick(1'b1, "realign R10");
            for (int i = 0; i < n; i++) tick(1'b0, "realign R10");
        end
        // back-to-back pulses
        for (int i = 0; i < 4; i++) tick(1'b1, "back-to-back R10");
        for (int i = 0; i < 300; i++) tick(1'b0, "after realign R9");
        // mid-reset recovery: R1 again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_locked = 1'b0; m_pos = 0; m_align = 1'b0; m_word = '0;
        for (int i = 0; i < 10; i++) tick(1'b0, "after second reset R1");
        tick(1'b1, "first frame aligned R3");
        for (int i = 0; i < 20; i++) tick(1'b0, "first frame aligned R3");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule